// File: doc/BRIEF.md
# Sampled Threshold Top-K Selector

This block picks out the high-priority entries of a table of key-priority pairs without sorting the whole table. A run starts with a one-cycle `start` pulse that captures three settings: the sample count, the rank K, and the table length. The first sample-count pairs accepted on the input stream are samples. Each sample is dropped into a sorted array of K_MAX slots at one sample per cycle. The priority at rank K in that array becomes an estimate of the K-th highest priority in the whole table.

The next table-length pairs on the same stream are the scan. Each scanned pair whose priority is strictly above the estimate has its key sent out one cycle later. When the last scanned pair has been accepted, `done` rises and stays high until the next run.

The sampling phase costs one cycle per sample, and storage grows with K_MAX only. The scan costs one cycle per entry, with a single comparison against the estimate.

Top module: `tks_select`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `done` are all low.
- R2: A `start` pulse seen while no run is active captures `cfg_k`, `cfg_s` and `cfg_n`, clears `done`, and raises `in_ready` on the following cycle. A `start` pulse during a run has no effect.
- R3: The first `cfg_s` pairs accepted after start (accepted means `in_valid` and `in_ready` both high) are samples. No sample ever produces an output.
- R4: The threshold equals the K-th largest of the sampled priorities, with duplicates counted as separate entries.
- R5: When `cfg_s` is smaller than K, the threshold is the smallest sampled priority.
- R6: Each of the next `cfg_n` accepted pairs with a priority strictly greater than the threshold produces `out_valid` high, with its key on `out_key`, exactly one cycle after acceptance. A pair whose priority is equal to or below the threshold produces no output.
- R7: One cycle after the `cfg_n`-th scanned pair is accepted, `done` goes high and `in_ready` goes low. `done` then holds until the next accepted `start`.
- R8: A cycle with `in_valid` low advances neither phase. No pair is consumed in that cycle.
- R9: A `cfg_k` of 0 is treated as K = 1, and a `cfg_k` above K_MAX is treated as K = K_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| cfg_k | input | $clog2(K_MAX+1) | Rank K of the threshold |
| cfg_s | input | CNT_W | Number of samples |
| cfg_n | input | CNT_W | Number of table entries scanned |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block accepts pairs (high during both phases) |
| in_key | input | KEY_W | Key of the input pair |
| in_pri | input | PRI_W | Priority of the input pair |
| out_valid | output | 1 | Selected key present |
| out_key | output | KEY_W | Key of a selected entry |
| done | output | 1 | Run finished, held until next start |

## Verification
The assertions assume that `cfg_s` and `cfg_n` are at least 1 whenever a run starts. A zero count would wrap the beat counter. The assertions also assume that `in_key` and `in_pri` carry meaningful data only while `in_valid` is high.

The stimulus always starts runs with nonzero counts. It drives random data on stall cycles so that ignored values are visible at the ports. It changes inputs only at the falling edge. `cfg_k` is deliberately pushed to 0 and above K_MAX, because the clamp is part of the defined behaviour rather than an input constraint.

// File: rtl/tks_pkg.sv
package tks_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_SCAN   = 2'd2
   } tks_phase_e;
endpackage

// File: rtl/tks_sorter.sv
// Parallel insertion array: slot 0 holds the largest priority seen so far.
// Every slot compares against the incoming sample in the same cycle.
module tks_sorter #(
   parameter int K_MAX = 4,
   parameter int PRI_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   ins,
   input  logic [PRI_W-1:0]       ins_pri,
   output logic [K_MAX*PRI_W-1:0] slot_pri,
   output logic [K_MAX-1:0]       slot_vld
);
   logic [PRI_W-1:0] pri_q [K_MAX];
   logic [K_MAX-1:0] vld_q;
   logic [K_MAX-1:0] beats;   // new sample belongs at or above this slot

   for (genvar i = 0; i < K_MAX; i++) begin : g_slot
      assign beats[i] = !vld_q[i] || (ins_pri > pri_q[i]);
      assign slot_pri[i*PRI_W +: PRI_W] = pri_q[i];

      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pri_q[i] <= '0;
               vld_q[i] <= 1'b0;
            end else if (clr) begin
               vld_q[i] <= 1'b0;
            end else if (ins && beats[i]) begin
               pri_q[i] <= ins_pri;
               vld_q[i] <= 1'b1;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pri_q[i] <= '0;
               vld_q[i] <= 1'b0;
            end else if (clr) begin
               vld_q[i] <= 1'b0;
            end else if (ins) begin
               if (beats[i-1]) begin
                  pri_q[i] <= pri_q[i-1];
                  vld_q[i] <= vld_q[i-1];
               end else if (beats[i]) begin
                  pri_q[i] <= ins_pri;
                  vld_q[i] <= 1'b1;
               end
            end
         end
      end
   end

   assign slot_vld = vld_q;
endmodule

// File: rtl/tks_thresh.sv
// Picks the lowest filled slot within the first k_eff slots.
module tks_thresh #(
   parameter int K_MAX = 4,
   parameter int PRI_W = 8,
   parameter int KW    = 3
) (
   input  logic [K_MAX*PRI_W-1:0] slot_pri,
   input  logic [K_MAX-1:0]       slot_vld,
   input  logic [KW-1:0]          k_eff,
   output logic [PRI_W-1:0]       thr
);
   always_comb begin
      thr = '0;
      for (int i = 0; i < K_MAX; i++) begin
         if (slot_vld[i] && (i < int'(k_eff)))
            thr = slot_pri[i*PRI_W +: PRI_W];
      end
   end
endmodule

// File: rtl/tks_ctrl.sv
module tks_ctrl
   import tks_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_valid,
   input  logic [CNT_W-1:0] cfg_s,
   input  logic [CNT_W-1:0] cfg_n,
   output tks_phase_e       phase,
   output logic [CNT_W-1:0] beat_cnt,
   output logic             load,
   output logic             smp_fire,
   output logic             scan_fire,
   output logic             in_ready,
   output logic             done
);
   logic [CNT_W-1:0] s_q, n_q;

   assign in_ready  = (phase != PH_IDLE);
   assign load      = (phase == PH_IDLE) && start;
   assign smp_fire  = (phase == PH_SAMPLE) && in_valid;
   assign scan_fire = (phase == PH_SCAN) && in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         beat_cnt <= '0;
         s_q      <= '0;
         n_q      <= '0;
         done     <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               s_q      <= cfg_s;
               n_q      <= cfg_n;
               beat_cnt <= '0;
               done     <= 1'b0;
               phase    <= PH_SAMPLE;
            end
            PH_SAMPLE: if (in_valid) begin
               if (beat_cnt == s_q - 1'b1) begin
                  beat_cnt <= '0;
                  phase    <= PH_SCAN;
               end else begin
                  beat_cnt <= beat_cnt + 1'b1;
               end
            end
            PH_SCAN: if (in_valid) begin
               if (beat_cnt == n_q - 1'b1) begin
                  beat_cnt <= '0;
                  done     <= 1'b1;
                  phase    <= PH_IDLE;
               end else begin
                  beat_cnt <= beat_cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tks_select.sv
module tks_select
   import tks_pkg::*;
#(
   parameter int K_MAX = 4,
   parameter int KEY_W = 8,
   parameter int PRI_W = 8,
   parameter int CNT_W = 12,
   localparam int KW   = $clog2(K_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [KW-1:0]    cfg_k,
   input  logic [CNT_W-1:0] cfg_s,
   input  logic [CNT_W-1:0] cfg_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [KEY_W-1:0] in_key,
   input  logic [PRI_W-1:0] in_pri,
   output logic             out_valid,
   output logic [KEY_W-1:0] out_key,
   output logic             done
);
   initial begin : p_elab
      assert (K_MAX >= 1) else $error("K_MAX must be at least 1");
      assert (PRI_W >= 1 && KEY_W >= 1) else $error("widths must be positive");
      assert (CNT_W >= 2) else $error("CNT_W too small");
   end

   tks_phase_e             phase;
   logic [CNT_W-1:0]       beat_cnt;
   logic                   load, smp_fire, scan_fire;
   logic [K_MAX*PRI_W-1:0] slot_pri;
   logic [K_MAX-1:0]       slot_vld;
   logic [KW-1:0]          k_q, k_clamped;
   logic [PRI_W-1:0]       thr;

   always_comb begin
      if (cfg_k == '0)                 k_clamped = KW'(1);
      else if (int'(cfg_k) > K_MAX)    k_clamped = KW'(K_MAX);
      else                             k_clamped = cfg_k;
   end

   tks_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .cfg_s(cfg_s), .cfg_n(cfg_n), .phase(phase), .beat_cnt(beat_cnt),
      .load(load), .smp_fire(smp_fire), .scan_fire(scan_fire),
      .in_ready(in_ready), .done(done)
   );

   tks_sorter #(.K_MAX(K_MAX), .PRI_W(PRI_W)) u_sorter (
      .clk(clk), .rst_n(rst_n), .clr(load), .ins(smp_fire),
      .ins_pri(in_pri), .slot_pri(slot_pri), .slot_vld(slot_vld)
   );

   tks_thresh #(.K_MAX(K_MAX), .PRI_W(PRI_W), .KW(KW)) u_thresh (
      .slot_pri(slot_pri), .slot_vld(slot_vld), .k_eff(k_q), .thr(thr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q       <= KW'(1);
         out_valid <= 1'b0;
         out_key   <= '0;
      end else begin
         if (load) k_q <= k_clamped;
         out_valid <= scan_fire && (in_pri > thr);
         if (scan_fire) out_key <= in_key;
      end
   end
endmodule

// File: rtl/tks_select_chk.sv
module tks_select_chk
   import tks_pkg::*;
#(
   parameter int K_MAX = 4,
   parameter int PRI_W = 8,
   parameter int CNT_W = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   done,
   input tks_phase_e             phase,
   input logic [CNT_W-1:0]       beat_cnt,
   input logic [K_MAX*PRI_W-1:0] slot_pri,
   input logic [K_MAX-1:0]       slot_vld
);
   for (genvar i = 0; i + 1 < K_MAX; i++) begin : g_ord
      AST_SLOTS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[i+1] |-> (slot_pri[i*PRI_W +: PRI_W] >= slot_pri[(i+1)*PRI_W +: PRI_W])); // R4
   end

   AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_vld & (slot_vld + 1'b1)) == '0)); // R4

   AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && in_ready)); // R6

   AST_NO_OUT_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(phase == PH_SCAN)); // R3

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R7

   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready); // R7

   AST_STALL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !in_valid) |=> $stable(beat_cnt)); // R8

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start) |=> (in_ready && !done)); // R2
endmodule

bind tks_select tks_select_chk #(.K_MAX(K_MAX), .PRI_W(PRI_W), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
   .in_ready(in_ready), .out_valid(out_valid), .done(done), .phase(phase),
   .beat_cnt(beat_cnt), .slot_pri(slot_pri), .slot_vld(slot_vld)
);

// File: tb/test_tks_select.sv
module test_tks_select;
   localparam int K_MAX = 4;
   localparam int KEY_W = 8;
   localparam int PRI_W = 8;
   localparam int CNT_W = 12;
   localparam int KW    = $clog2(K_MAX + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [KW-1:0]    cfg_k = '0;
   logic [CNT_W-1:0] cfg_s = '0;
   logic [CNT_W-1:0] cfg_n = '0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [KEY_W-1:0] in_key = '0;
   logic [PRI_W-1:0] in_pri = '0;
   logic             out_valid;
   logic [KEY_W-1:0] out_key;
   logic             done;

   always #10 clk = ~clk;

   tks_select #(.K_MAX(K_MAX), .KEY_W(KEY_W), .PRI_W(PRI_W), .CNT_W(CNT_W)) i_tks_select (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_s(cfg_s),
      .cfg_n(cfg_n), .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
      .in_pri(in_pri), .out_valid(out_valid), .out_key(out_key), .done(done)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // behavioural reference model
   int m_phase = 0;           // 0 idle, 1 sampling, 2 scanning
   int m_cnt = 0, m_k = 1, m_s = 0, m_n = 0, m_thr = 0;
   int m_samples[$];
   bit m_ready = 0, m_oval = 0, m_done = 0;
   int m_okey = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(in_ready === m_ready, "R2 R7 R8 in_ready", int'(in_ready), int'(m_ready));
      chk(out_valid === m_oval, "R3 R4 R5 R6 out_valid", int'(out_valid), int'(m_oval));
      chk(done === m_done, "R7 done", int'(done), int'(m_done));
      if (m_oval) chk(int'(out_key) == m_okey, "R6 out_key", int'(out_key), m_okey);
   endtask

   function automatic void model_next(input bit st, input bit v, input int key, input int pri);
      int q[$];
      int idx;
      m_oval = 0;
      case (m_phase)
         0: if (st) begin
            m_k = (int'(cfg_k) == 0) ? 1 : ((int'(cfg_k) > K_MAX) ? K_MAX : int'(cfg_k));
            m_s = int'(cfg_s); m_n = int'(cfg_n);
            m_samples.delete(); m_cnt = 0; m_done = 0; m_phase = 1;
         end
         1: if (v) begin
            m_samples.push_back(pri);
            m_cnt++;
            if (m_cnt == m_s) begin
               q = m_samples;
               q.rsort();
               idx = (m_k < q.size()) ? m_k : q.size();
               m_thr = q[idx-1];
               m_cnt = 0; m_phase = 2;
            end
         end
         default: if (v) begin
            m_oval = (pri > m_thr);
            m_okey = key;
            m_cnt++;
            if (m_cnt == m_n) begin m_phase = 0; m_done = 1; end
         end
      endcase
      m_ready = (m_phase != 0);
   endfunction

   task automatic step(input bit st, input bit v, input int key, input int pri);
      @(negedge clk);
      compare_all();
      start = st; in_valid = v; in_key = KEY_W'(key); in_pri = PRI_W'(pri);
      model_next(st, v, key, pri);
   endtask

   task automatic run(input int k, input int s, input int n, input int pmax,
                      input int gap_pct, input bit poke_start);
      cfg_k = KW'(k); cfg_s = CNT_W'(s); cfg_n = CNT_W'(n);
      step(1'b1, 1'b0, 0, 0);
      while (m_phase != 0) begin
         automatic bit v  = ($urandom_range(99) >= gap_pct);
         automatic bit st = poke_start && ($urandom_range(9) == 0);
         step(st, v, $urandom_range(255), $urandom_range(pmax));
      end
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, $urandom_range(255), $urandom_range(255));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready === 1'b0, "R1 in_ready", int'(in_ready), 0);
      chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
      chk(done === 1'b0, "R1 done", int'(done), 0);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 5, 200);                 // R2: input ignored while idle
      run(4, 8, 24, 255, 0, 0);                 // R4 R6 wide priorities
      run(2, 6, 20, 3, 30, 0);                  // R6 ties at threshold, R8 stalls
      run(4, 2, 12, 50, 0, 0);                  // R5 fewer samples than K
      run(0, 5, 10, 40, 10, 0);                 // R9 K of zero
      run(7, 9, 10, 40, 10, 0);                 // R9 K above K_MAX
      run(1, 1, 1, 255, 0, 0);                  // R3 R7 shortest run
      run(3, 7, 30, 20, 60, 1);                 // R2 start ignored mid-run, R8
      for (int r = 0; r < 6; r++)
         run($urandom_range(1, 4), $urandom_range(1, 12), $urandom_range(1, 40),
             $urandom_range(1, 255), $urandom_range(0, 50), 1);
      step(1'b0, 1'b0, 0, 0);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog R7 actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule